// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Alignment Hunter

This block follows an E1 receiver that already holds basic-frame alignment. On each frame strobe it takes the international bit of timeslot 0 and the frame type (alignment-signal frame or not). From these it finds the CRC-4 multiframe boundary. The alignment word is 001011. It is carried on the six odd frames 1, 3, 5, 7, 9 and 11 of a 16-frame multiframe. Every timing decision is counted in frames, at 125 µs per frame.

The hunt starts once basic-frame sync and CRC enable are both high. Sync is declared when two alignment words arrive within a 64-frame window and their spacing is a whole number of multiframes. If the window runs out first, the block asks the basic-frame aligner for an offline re-search. It then waits until that search reports a new alignment, and restarts the window. A 3200-frame overall timer runs across all of these retries. When it expires, the block falls back to CRC-to-non-CRC interworking. In interworking, hunting carries on only while the continue-check input is high. Once in sync, the block tracks the multiframe position and pulses an error on every corrupted alignment word.

Top module: `e1_mf_align`

## Requirements
- R1: After reset, and while `bfa_i` or `crc_en_i` is low, the outputs are in the idle state: `oomf_o`=1, `resync_req_o`=0, `interwork_o`=0, `mf_err_o`=0 and `mf_cnt_o`=0.
- R2: The alignment word is built from the `si_i` bits of frames with `fas_i`=0, in arrival order. The first-received bit is the leftmost, and the word must equal 001011.
- R3: A first matching word alone keeps `oomf_o`=1 and loads `mf_cnt_o` with 11. A second match that lands a whole number of 16-frame multiframes later clears `oomf_o` after that frame.
- R4: A match that lands at a different phase does not lock. Instead it becomes the new first word and reloads `mf_cnt_o` with 11.
- R5: While in sync, `mf_cnt_o` advances by one, modulo 16, on each frame strobe and equals the index of the last received frame.
- R6: In sync, a frame-11 word that differs from 001011 gives `mf_err_o`=1 for exactly one cycle, and `oomf_o` stays 0.
- R7: If 64 hunt frames pass without lock, `resync_req_o` goes to 1 after the 64th frame and stays high until `resync_done_i` is pulsed. That pulse restarts a fresh 64-frame window.
- R8: If 3200 frames pass in hunt or re-search without lock, `interwork_o` becomes 1 and `resync_req_o` drops to 0. After 3199 such frames, `interwork_o` is still 0.
- R9: In interworking, matching words are ignored while `keep_chk_i`=0. With `keep_chk_i`=1 the hunt resumes, and a lock sets `oomf_o`=0 and `interwork_o`=0.
- R10: When the lock-completing second word falls on the last frame of the 64-frame window, the block locks and raises no re-search request.
- R11: When `bfa_i` or `crc_en_i` drops, the block returns to the idle outputs of R1 on the next clock, even from sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe per received frame |
| si_i | input | 1 | International bit of timeslot 0 for this frame |
| fas_i | input | 1 | 1 for a frame carrying the frame alignment signal, 0 otherwise |
| bfa_i | input | 1 | Basic-frame alignment held |
| resync_done_i | input | 1 | Pulse: offline basic-frame search found a new alignment |
| crc_en_i | input | 1 | CRC-4 multiframe hunting enabled |
| keep_chk_i | input | 1 | Keep hunting while in interworking |
| oomf_o | output | 1 | Out of multiframe alignment |
| mf_err_o | output | 1 | One-cycle pulse: received alignment word was corrupted |
| resync_req_o | output | 1 | Request for an offline basic-frame search |
| interwork_o | output | 1 | CRC-to-non-CRC interworking declared |
| mf_cnt_o | output | 4 | Multiframe frame index |

## Verification
The close call is the lock rule against the window timer. Both can act on the same frame strobe, when the second alignment word arrives on the 64th frame of the window. The bench arranges this by sending 36 filler frames before two well-formed multiframes, so that the second word ends exactly on the window's last frame. The result is judged at the ports: `oomf_o` must fall and `resync_req_o` must stay low. The opposite order is covered by a window that carries no word at all, and there the request must appear after frame 64 and not after frame 63.

// File: rtl/e1_mf_pkg.sv
package e1_mf_pkg;
  localparam int unsigned MF_LEN   = 16;
  localparam int unsigned CNT_W    = $clog2(MF_LEN);
  localparam int unsigned WORD_W   = 6;
  localparam logic [WORD_W-1:0] ALIGN_WORD = 6'b001011;
  localparam logic [CNT_W-1:0]  WORD_END   = CNT_W'(11);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_WAIT,
    ST_IWK,
    ST_SYNC
  } mf_state_e;
endpackage

// File: rtl/e1_mf_frame_timer.sv
module e1_mf_frame_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign hit_o = en_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (hit_o)    cnt_q <= '0;
    else if (en_i)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/e1_mf_word_det.sv
module e1_mf_word_det
  import e1_mf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic frame_i,
  input  logic si_i,
  input  logic fas_i,
  output logic word_ok_o,
  output logic match_o
);
  logic [WORD_W-2:0] sr_q;
  logic [WORD_W-1:0] word;
  logic              nfas_stb;

  assign nfas_stb  = frame_i && !fas_i;
  // newest bit sits at the right, first-received at the left
  assign word      = {sr_q, si_i};
  assign word_ok_o = (word == ALIGN_WORD);
  assign match_o   = nfas_stb && word_ok_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '1;
    else if (!run_i)   sr_q <= '1;
    else if (nfas_stb) sr_q <= word[WORD_W-2:0];
  end
endmodule

// File: rtl/e1_mf_ctrl.sv
module e1_mf_ctrl
  import e1_mf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             frame_i,
  input  logic             match_i,
  input  logic             word_ok_i,
  input  logic             win_hit_i,
  input  logic             tot_hit_i,
  input  logic             resync_done_i,
  input  logic             keep_chk_i,
  output mf_state_e        state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_o
);
  mf_state_e        state_q, state_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             err_q, err_d;
  logic             hunt_on;

  assign cnt_inc = cnt_q + 1'b1;
  assign hunt_on = (state_q == ST_HUNT) || ((state_q == ST_IWK) && keep_chk_i);

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    err_d   = 1'b0;
    if (!run_i) begin
      state_d = ST_IDLE;
      armed_d = 1'b0;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_HUNT;
          armed_d = 1'b0;
          cnt_d   = '0;
        end
        ST_HUNT, ST_IWK: begin
          if (!hunt_on) armed_d = 1'b0;
          if (frame_i) begin
            cnt_d = cnt_inc;
            if (!hunt_on) begin
              armed_d = 1'b0;
            end else if (match_i && armed_q && (cnt_inc == WORD_END)) begin
              // lock outranks both timers
              state_d = ST_SYNC;
              armed_d = 1'b0;
            end else if ((state_q == ST_HUNT) && tot_hit_i) begin
              state_d = ST_IWK;
              armed_d = 1'b0;
            end else if (win_hit_i) begin
              armed_d = 1'b0;
              if (state_q == ST_HUNT) state_d = ST_WAIT;
            end else if (match_i) begin
              armed_d = 1'b1;
              cnt_d   = WORD_END;
            end
          end
        end
        ST_WAIT: begin
          if (frame_i) cnt_d = cnt_inc;
          if (frame_i && tot_hit_i) state_d = ST_IWK;
          else if (resync_done_i)   state_d = ST_HUNT;
        end
        ST_SYNC: begin
          if (frame_i) begin
            cnt_d = cnt_inc;
            err_d = (cnt_inc == WORD_END) && !word_ok_i;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign err_o   = err_q;
endmodule

// File: rtl/e1_mf_align.sv
module e1_mf_align
  import e1_mf_pkg::*;
#(
  parameter int unsigned WIN_FRAMES   = 64,
  parameter int unsigned TOTAL_FRAMES = 3200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             si_i,
  input  logic             fas_i,
  input  logic             bfa_i,
  input  logic             resync_done_i,
  input  logic             crc_en_i,
  input  logic             keep_chk_i,
  output logic             oomf_o,
  output logic             mf_err_o,
  output logic             resync_req_o,
  output logic             interwork_o,
  output logic [CNT_W-1:0] mf_cnt_o
);
  logic      run;
  logic      word_ok, match;
  logic      win_hit, tot_hit;
  logic      win_act, tot_act;
  mf_state_e state;

  assign run     = bfa_i && crc_en_i;
  assign win_act = (state == ST_HUNT) || ((state == ST_IWK) && keep_chk_i);
  assign tot_act = (state == ST_HUNT) || (state == ST_WAIT);

  e1_mf_word_det u_word (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .frame_i  (frame_i),
    .si_i     (si_i),
    .fas_i    (fas_i),
    .word_ok_o(word_ok),
    .match_o  (match)
  );

  e1_mf_frame_timer #(.LIMIT(WIN_FRAMES)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!run || !win_act),
    .en_i  (frame_i && win_act),
    .hit_o (win_hit)
  );

  e1_mf_frame_timer #(.LIMIT(TOTAL_FRAMES)) u_tot (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!run || !tot_act),
    .en_i  (frame_i && tot_act),
    .hit_o (tot_hit)
  );

  e1_mf_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .frame_i      (frame_i),
    .match_i      (match),
    .word_ok_i    (word_ok),
    .win_hit_i    (win_hit),
    .tot_hit_i    (tot_hit),
    .resync_done_i(resync_done_i),
    .keep_chk_i   (keep_chk_i),
    .state_o      (state),
    .cnt_o        (mf_cnt_o),
    .err_o        (mf_err_o)
  );

  assign oomf_o       = (state != ST_SYNC);
  assign resync_req_o = (state == ST_WAIT);
  assign interwork_o  = (state == ST_IWK);
endmodule

// File: rtl/e1_mf_align_chk.sv
module e1_mf_align_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_i,
  input logic       fas_i,
  input logic       bfa_i,
  input logic       resync_done_i,
  input logic       crc_en_i,
  input logic       oomf_o,
  input logic       mf_err_o,
  input logic       resync_req_o,
  input logic       interwork_o,
  input logic [3:0] mf_cnt_o
);
  a_r1_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bfa_i && crc_en_i) |=> (oomf_o && !resync_req_o && !interwork_o && mf_cnt_o == 4'd0));

  a_r3_lock_on_nfas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oomf_o && $past(oomf_o)) |-> $past(frame_i && !fas_i));

  a_r5_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oomf_o && !$past(oomf_o) && $past(frame_i)) |-> (mf_cnt_o == 4'($past(mf_cnt_o) + 4'd1)));

  a_r5_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oomf_o && !$past(oomf_o) && !$past(frame_i)) |-> $stable(mf_cnt_o));

  a_r6_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_err_o |=> !mf_err_o);

  a_r6_err_in_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_err_o |-> !oomf_o);

  a_r7_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resync_req_o && !resync_done_i && !frame_i && bfa_i && crc_en_i) |=> resync_req_o);

  a_r8_iw_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    interwork_o |-> (oomf_o && !resync_req_o));
endmodule

bind e1_mf_align e1_mf_align_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_i      (frame_i),
  .fas_i        (fas_i),
  .bfa_i        (bfa_i),
  .resync_done_i(resync_done_i),
  .crc_en_i     (crc_en_i),
  .oomf_o       (oomf_o),
  .mf_err_o     (mf_err_o),
  .resync_req_o (resync_req_o),
  .interwork_o  (interwork_o),
  .mf_cnt_o     (mf_cnt_o)
);

// File: tb/tb_e1_mf_align.sv
module tb_e1_mf_align;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame = 1'b0, si = 1'b1, fas = 1'b0;
  logic       bfa = 1'b0, done = 1'b0, crc_en = 1'b0, keep = 1'b0;
  logic       oomf, err, req, iw;
  logic [3:0] cnt;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  localparam logic [5:0] WORD = 6'b001011;

  always #2 clk = ~clk;

  e1_mf_align dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .si_i(si), .fas_i(fas),
    .bfa_i(bfa), .resync_done_i(done), .crc_en_i(crc_en), .keep_chk_i(keep),
    .oomf_o(oomf), .mf_err_o(err), .resync_req_o(req), .interwork_o(iw),
    .mf_cnt_o(cnt)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic frm(logic s, logic f);
    @(negedge clk);
    frame = 1'b1; si = s; fas = f;
    @(negedge clk);
    frame = 1'b0; si = 1'b1;
  endtask

  // frames with no alignment word, FAS on even k
  task automatic fillers(int n);
    for (int k = 0; k < n; k++) frm(1'b1, (k % 2) == 0);
  endtask

  // stream positions p (mod 16); bad_p flips that frame's Si bit
  task automatic stream(int p0, int p1, int bad_p = -1);
    for (int p = p0; p <= p1; p++) begin
      int  q = p % 16;
      logic b = 1'b1;
      if ((q % 2) == 1 && q < 12) b = WORD[5 - (q - 1) / 2];
      if (p == bad_p) b = ~b;
      frm(b, (q % 2) == 0);
    end
  endtask

  task automatic restart();
    @(negedge clk);
    bfa = 1'b0; crc_en = 1'b1; keep = 1'b0; done = 1'b0;
    @(negedge clk);
    bfa = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 oomf", oomf, 1);
    check("R1 req", req, 0);
    check("R1 iw", iw, 0);
    check("R1 err", err, 0);
    check("R1 cnt", cnt, 0);
  endtask

  task automatic t_lock();
    restart();
    stream(0, 11);
    check("R3 single word no lock", oomf, 1);
    check("R3 anchor count", cnt, 11);
    stream(12, 26);
    check("R3 before second word", oomf, 1);
    stream(27, 27);
    check("R2 R3 lock", oomf, 0);
    check("R5 count at word", cnt, 11);
    stream(28, 28);
    check("R5 count step", cnt, 12);
    stream(29, 32);
    check("R5 count wrap", cnt, 0);
  endtask

  task automatic t_err();
    stream(33, 43, 37);
    check("R6 err pulse", err, 1);
    check("R6 still sync", oomf, 0);
    @(negedge clk);
    check("R6 one cycle", err, 0);
    stream(44, 59);
    check("R6 clean word", err, 0);
    check("R6 sync kept", oomf, 0);
  endtask

  task automatic t_phase();
    restart();
    stream(0, 15);
    fillers(2);
    stream(0, 11);
    check("R4 off-phase no lock", oomf, 1);
    check("R4 reanchor", cnt, 11);
    stream(12, 27);
    check("R4 lock after reanchor", oomf, 0);
  endtask

  task automatic t_window();
    restart();
    fillers(63);
    check("R7 no req at 63", req, 0);
    fillers(1);
    check("R7 req at 64", req, 1);
    check("R7 oomf", oomf, 1);
    fillers(4);
    check("R7 req held", req, 1);
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    check("R7 req released", req, 0);
    stream(0, 27);
    check("R7 lock after restart", oomf, 0);
  endtask

  task automatic t_coincide();
    restart();
    fillers(36);
    stream(0, 27);
    check("R10 lock on last window frame", oomf, 0);
    check("R10 no req", req, 0);
  endtask

  task automatic t_iwk();
    restart();
    fillers(3199);
    check("R8 no iw at 3199", iw, 0);
    check("R8 req pending", req, 1);
    fillers(1);
    check("R8 iw", iw, 1);
    check("R8 req dropped", req, 0);
    check("R8 oomf", oomf, 1);
    stream(0, 47);
    check("R9 ignored without keep", oomf, 1);
    check("R9 iw held", iw, 1);
    @(negedge clk); keep = 1'b1;
    stream(0, 27);
    check("R9 lock with keep", oomf, 0);
    check("R9 iw cleared", iw, 0);
  endtask

  task automatic t_drop();
    restart();
    stream(0, 27);
    check("R11 pre lock", oomf, 0);
    @(negedge clk); bfa = 1'b0;
    @(negedge clk);
    check("R11 bfa loss oomf", oomf, 1);
    check("R11 bfa loss cnt", cnt, 0);
    restart();
    stream(0, 27);
    @(negedge clk); crc_en = 1'b0;
    @(negedge clk);
    check("R11 crc off oomf", oomf, 1);
    check("R1 idle iw", iw, 0);
    check("R1 idle req", req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_err();
    t_phase();
    t_window();
    t_coincide();
    t_iwk();
    t_drop();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule